// File: doc/BRIEF.md
# Endian-Aware Halfword Load Formatter

This block sits between the read port of a data memory and the register writeback path, and it turns a fetched memory word into the 32-bit value that a halfword load writes back. It takes the word returned by memory, the low bits of the access address, a byte-order select, a signed/unsigned select and a strict-alignment enable. It picks the two addressed bytes, orders them for the selected endianness, and places the halfword in the low 16 bits of the result. It then sign-extends or zero-extends that halfword to the full result width.

An access can also fail to produce data. With strict alignment on, an odd address raises a misalignment fault with a fixed status code. With strict alignment off, an offset whose byte pair would cross the word boundary is reported as unsupported. In both cases the writeback enable stays low. All outputs are registered and follow an accepted request by exactly one clock.

Top module: `hw_load_fmt`

## Requirements
- R1: While rst_ni is low, every output reads zero: valid_o, wb_en_o, wb_data_o, fault_o, fault_code_o and unsup_o.
- R2: valid_o is high in the cycle after valid_i was high, and low in the cycle after valid_i was low.
- R3: Memory byte at offset k within the word is rdata_i[8k+7:8k]. The first byte of the pair is taken at offset addr_lo_i and the second at addr_lo_i+1.
- R4: With big_end_i low, the first byte becomes result bits [7:0] and the second byte becomes bits [15:8].
- R5: With big_end_i high, the first byte becomes result bits [15:8] and the second byte becomes bits [7:0].
- R6: With signed_i high, result bits [31:16] each equal result bit 15.
- R7: With signed_i low, result bits [31:16] are zero.
- R8: If strict_i is high and addr_lo_i[0] is 1, the next cycle shows fault_o high, fault_code_o equal to 4'h1, wb_en_o low and wb_data_o zero. fault_o falls again in the cycle after the next request that does not fault.
- R9: fault_code_o is 4'h0 whenever fault_o is low.
- R10: If strict_i is low and addr_lo_i is 3, the next cycle shows unsup_o high, wb_en_o low, fault_o low and wb_data_o zero.
- R11: In the cycle after valid_i was low, wb_data_o keeps its previous value and wb_en_o, fault_o and unsup_o are low.
- R12: If strict_i is low, offsets 1 and 2 both deliver data with wb_en_o high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| valid_i | input | 1 | Load data and controls are valid |
| rdata_i | input | 32 | Word read from memory |
| addr_lo_i | input | 2 | Byte offset of the access within the word |
| big_end_i | input | 1 | 1 selects big-endian byte order |
| signed_i | input | 1 | 1 selects sign extension |
| strict_i | input | 1 | 1 enables the strict alignment check |
| valid_o | output | 1 | Registered copy of valid_i |
| wb_en_o | output | 1 | Writeback enable |
| wb_data_o | output | 32 | Formatted writeback value |
| fault_o | output | 1 | Misalignment fault |
| fault_code_o | output | 4 | Fault status code |
| unsup_o | output | 1 | Access crosses the word boundary |

## Verification
The bench builds the block with its default parameters: a 32-bit word, four byte lanes and a 32-bit result. With four lanes, every byte offset can be driven, including offset 3, the one that crosses the word boundary, together with the offsets that do and do not fault under each setting of the strict enable. The bench sweeps all combinations of byte order, extension and strictness over every offset, using random words and words that sit on the sign boundary. Each result is compared with a behavioural model that extracts bytes by arithmetic shifting.

// File: rtl/hw_load_pkg.sv
package hw_load_pkg;
  localparam int unsigned FSC_W = 4;
  localparam logic [FSC_W-1:0] FSC_MISALIGN = 4'h1;
  localparam logic [FSC_W-1:0] FSC_NONE     = 4'h0;

  typedef enum logic [1:0] {
    ACC_OK       = 2'd0,
    ACC_MISALIGN = 2'd1,
    ACC_SPLIT    = 2'd2
  } acc_kind_e;
endpackage

// File: rtl/hw_lane_pick.sv
module hw_lane_pick #(
  parameter int unsigned DATA_W = 32,
  localparam int unsigned BYTES = DATA_W / 8,
  localparam int unsigned OFF_W = $clog2(BYTES)
) (
  input  logic [DATA_W-1:0] word_i,
  input  logic [OFF_W-1:0]  off_i,
  input  logic              big_end_i,
  output logic [15:0]       half_o
);
  logic [7:0]       lane [BYTES];
  logic [OFF_W-1:0] nxt;
  logic [7:0]       b_first, b_second;

  for (genvar g = 0; g < BYTES; g++) begin : g_lane
    assign lane[g] = word_i[8*g +: 8];
  end

  // wraps on the last lane; that case is flagged by the alignment check
  assign nxt      = off_i + OFF_W'(1);
  assign b_first  = lane[off_i];
  assign b_second = lane[nxt];

  always_comb begin
    if (big_end_i) half_o = {b_first, b_second};
    else           half_o = {b_second, b_first};
  end
endmodule

// File: rtl/hw_align_chk.sv
module hw_align_chk
  import hw_load_pkg::*;
#(
  parameter int unsigned OFF_W = 2
) (
  input  logic [OFF_W-1:0] off_i,
  input  logic             strict_i,
  output acc_kind_e        kind_o
);
  always_comb begin
    if (strict_i && off_i[0])        kind_o = ACC_MISALIGN;
    else if (!strict_i && &off_i)    kind_o = ACC_SPLIT;
    else                             kind_o = ACC_OK;
  end
endmodule

// File: rtl/hw_extend.sv
module hw_extend #(
  parameter int unsigned RES_W = 32,
  localparam int unsigned PAD_W = RES_W - 16
) (
  input  logic [15:0]      half_i,
  input  logic             signed_i,
  output logic [RES_W-1:0] res_o
);
  logic fill;
  assign fill  = signed_i & half_i[15];
  assign res_o = {{PAD_W{fill}}, half_i};
endmodule

// File: rtl/hw_load_fmt.sv
module hw_load_fmt
  import hw_load_pkg::*;
#(
  parameter int unsigned DATA_W = 32,
  parameter int unsigned RES_W  = 32,
  localparam int unsigned BYTES = DATA_W / 8,
  localparam int unsigned OFF_W = $clog2(BYTES)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              valid_i,
  input  logic [DATA_W-1:0] rdata_i,
  input  logic [OFF_W-1:0]  addr_lo_i,
  input  logic              big_end_i,
  input  logic              signed_i,
  input  logic              strict_i,
  output logic              valid_o,
  output logic              wb_en_o,
  output logic [RES_W-1:0]  wb_data_o,
  output logic              fault_o,
  output logic [FSC_W-1:0]  fault_code_o,
  output logic              unsup_o
);
  logic [15:0]      half;
  logic [RES_W-1:0] ext;
  acc_kind_e        kind;

  hw_lane_pick #(.DATA_W(DATA_W)) i_pick (
    .word_i   (rdata_i),
    .off_i    (addr_lo_i),
    .big_end_i(big_end_i),
    .half_o   (half)
  );

  hw_align_chk #(.OFF_W(OFF_W)) i_chk_al (
    .off_i   (addr_lo_i),
    .strict_i(strict_i),
    .kind_o  (kind)
  );

  hw_extend #(.RES_W(RES_W)) i_ext (
    .half_i  (half),
    .signed_i(signed_i),
    .res_o   (ext)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_o      <= 1'b0;
      wb_en_o      <= 1'b0;
      wb_data_o    <= '0;
      fault_o      <= 1'b0;
      fault_code_o <= FSC_NONE;
      unsup_o      <= 1'b0;
    end else begin
      valid_o      <= valid_i;
      wb_en_o      <= valid_i && (kind == ACC_OK);
      fault_o      <= valid_i && (kind == ACC_MISALIGN);
      fault_code_o <= (valid_i && (kind == ACC_MISALIGN)) ? FSC_MISALIGN : FSC_NONE;
      unsup_o      <= valid_i && (kind == ACC_SPLIT);
      if (valid_i) wb_data_o <= (kind == ACC_OK) ? ext : '0;
    end
  end
endmodule

// File: rtl/hw_load_fmt_chk.sv
module hw_load_fmt_chk
  import hw_load_pkg::*;
#(
  parameter int unsigned RES_W = 32,
  parameter int unsigned OFF_W = 2
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             valid_i,
  input logic [OFF_W-1:0] addr_lo_i,
  input logic             signed_i,
  input logic             strict_i,
  input logic             valid_o,
  input logic             wb_en_o,
  input logic [RES_W-1:0] wb_data_o,
  input logic             fault_o,
  input logic [FSC_W-1:0] fault_code_o,
  input logic             unsup_o
);
  a_r2_valid_follows: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i |=> valid_o);
  a_r2_valid_drops: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_i |=> !valid_o);
  a_r6_sign_fill: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && signed_i) |=> (wb_data_o[RES_W-1:16] == {(RES_W-16){wb_data_o[15]}}));
  a_r7_zero_fill: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && !signed_i) |=> (wb_data_o[RES_W-1:16] == '0));
  a_r8_fault_raise: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && strict_i && addr_lo_i[0]) |=> (fault_o && !wb_en_o && fault_code_o == FSC_MISALIGN));
  a_r9_code_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !fault_o |-> (fault_code_o == FSC_NONE));
  a_r10_split_no_wb: assert property (@(posedge clk_i) disable iff (!rst_ni)
    unsup_o |-> (!wb_en_o && !fault_o));
  a_r11_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_i |=> ($stable(wb_data_o) && !wb_en_o && !fault_o && !unsup_o));
endmodule

bind hw_load_fmt hw_load_fmt_chk #(.RES_W(RES_W), .OFF_W(OFF_W)) i_hw_load_fmt_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .valid_i     (valid_i),
  .addr_lo_i   (addr_lo_i),
  .signed_i    (signed_i),
  .strict_i    (strict_i),
  .valid_o     (valid_o),
  .wb_en_o     (wb_en_o),
  .wb_data_o   (wb_data_o),
  .fault_o     (fault_o),
  .fault_code_o(fault_code_o),
  .unsup_o     (unsup_o)
);

// File: tb/test_hw_load_fmt.sv
module test_hw_load_fmt;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        valid_i = 1'b0;
  logic [31:0] rdata_i = '0;
  logic [1:0]  addr_lo_i = '0;
  logic        big_end_i = 1'b0, signed_i = 1'b0, strict_i = 1'b0;
  logic        valid_o, wb_en_o, fault_o, unsup_o;
  logic [31:0] wb_data_o;
  logic [3:0]  fault_code_o;

  int n_chk = 0, n_fail = 0;

  always #2 clk_i = ~clk_i;

  hw_load_fmt i_hw_load_fmt (
    .clk_i(clk_i), .rst_ni(rst_ni), .valid_i(valid_i), .rdata_i(rdata_i),
    .addr_lo_i(addr_lo_i), .big_end_i(big_end_i), .signed_i(signed_i),
    .strict_i(strict_i), .valid_o(valid_o), .wb_en_o(wb_en_o),
    .wb_data_o(wb_data_o), .fault_o(fault_o), .fault_code_o(fault_code_o),
    .unsup_o(unsup_o)
  );

  task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] ref_value(logic [31:0] w, int off, bit be, bit sg);
    int lo, hi, h;
    lo = int'((w >> (8*off)) & 32'hFF);
    hi = int'((w >> (8*(off+1))) & 32'hFF);
    h  = be ? lo*256 + hi : hi*256 + lo;
    if (sg && h >= 32768) return 32'(h) | 32'hFFFF0000;
    return 32'(h);
  endfunction

  // called at a negedge; returns at the following negedge
  task automatic xfer(input logic [31:0] w, input int off, input bit be, input bit sg, input bit st);
    bit fault_exp, split_exp;
    logic [31:0] exp;
    valid_i = 1'b1; rdata_i = w; addr_lo_i = 2'(off);
    big_end_i = be; signed_i = sg; strict_i = st;
    fault_exp = st && (off % 2 == 1);
    split_exp = !st && off == 3;
    exp = (fault_exp || split_exp) ? 32'h0 : ref_value(w, off, be, sg);
    @(posedge clk_i); #1;
    check(valid_o == 1'b1, "R2 valid_o after request", 32'(valid_o), 1);
    check(fault_o == fault_exp, "R8 fault_o", 32'(fault_o), 32'(fault_exp));
    check(fault_code_o == (fault_exp ? 4'h1 : 4'h0), "R8/R9 fault_code_o",
          32'(fault_code_o), fault_exp ? 1 : 0);
    check(unsup_o == split_exp, "R10 unsup_o", 32'(unsup_o), 32'(split_exp));
    check(wb_en_o == !(fault_exp || split_exp), "R12 wb_en_o", 32'(wb_en_o),
          32'(!(fault_exp || split_exp)));
    if (be) check(wb_data_o[15:0] == exp[15:0], "R5/R3 big-endian halfword", wb_data_o, exp);
    else    check(wb_data_o[15:0] == exp[15:0], "R4/R3 little-endian halfword", wb_data_o, exp);
    if (sg) check(wb_data_o == exp, "R6 sign extension", wb_data_o, exp);
    else    check(wb_data_o == exp, "R7 zero extension", wb_data_o, exp);
    @(negedge clk_i);
  endtask

  task automatic idle_cycle();
    logic [31:0] prev;
    prev = wb_data_o;
    valid_i = 1'b0; rdata_i = ~rdata_i; addr_lo_i = 2'd0; strict_i = 1'b0;
    @(posedge clk_i); #1;
    check(wb_data_o == prev, "R11 data held", wb_data_o, prev);
    check(!wb_en_o && !fault_o && !unsup_o, "R11 strobes low",
          {29'h0, wb_en_o, fault_o, unsup_o}, 0);
    check(valid_o == 1'b0, "R2 valid_o low", 32'(valid_o), 0);
    @(negedge clk_i);
  endtask

  initial begin
    repeat (200000) @(posedge clk_i);
    n_chk++; n_fail++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk_i);
    check({valid_o, wb_en_o, fault_o, unsup_o} == 4'b0 && wb_data_o == 0 && fault_code_o == 0,
          "R1 reset outputs", wb_data_o | {valid_o, wb_en_o, fault_o, unsup_o, fault_code_o}, 0);
    rst_ni = 1'b1;
    @(negedge clk_i);
    // directed boundary words
    xfer(32'h80FF7F01, 0, 0, 1, 1);
    xfer(32'h80FF7F01, 2, 1, 1, 1);
    xfer(32'h0080807F, 1, 0, 1, 0);
    xfer(32'h0080807F, 1, 1, 1, 0);
    xfer(32'h12345678, 2, 0, 0, 0);
    xfer(32'hAABBCCDD, 3, 0, 1, 0);   // R10 split
    xfer(32'hAABBCCDD, 3, 1, 0, 1);   // R8 fault
    xfer(32'h11223344, 0, 0, 0, 1);   // fault clears
    idle_cycle();
    for (int be = 0; be < 2; be++)
      for (int sg = 0; sg < 2; sg++)
        for (int st = 0; st < 2; st++)
          for (int off = 0; off < 4; off++)
            for (int rep = 0; rep < 4; rep++) begin
              xfer($urandom, off, be[0], sg[0], st[0]);
              if (rep == 3) idle_cycle();
            end
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule